// File: doc/BRIEF.md
# Dual-Source Interrupt Down-Counter

This block is a programmable interrupt timer. An 8-bit down-counter is advanced by one of two sources. The first is a pulse that the video side sends once per drawn line. The second is the processor cycle-enable, divided by four in a small prescaler. When the counter reaches zero from a decrement while interrupts are armed, a level-sensitive interrupt request is raised on the next processor cycle. The request then stays high until software acknowledges it.

Software controls the block through four write locations in the upper address range. An even address in the lower window loads the reload value. An odd address in the lower window picks the clock source. Both of these force a reload on the next counter clock. In the upper window, an odd address arms interrupts. An even address disarms them, drops the request and loads the counter from the reload value. A forced reload loads the reload value plus one, so a reload value of N gives N+1 clocks before the interrupt.

Top module: `irq_downcounter`

## Requirements
- R1: After reset, the request is low, interrupts are disarmed and line pulses are the clock source. The counter, the reload value and the prescaler are all zero, and no forced reload is pending.
- R2: A write with address bits [15:13]=3'b110 and address bit 0 = 0 stores the 8-bit data as the reload value and marks a forced reload as pending.
- R3: A write with address bits [15:13]=3'b110 and address bit 0 = 1 marks a forced reload as pending. Data bit 0 picks the source: 1 selects processor cycles and 0 selects line pulses.
- R4: A write with address bits [15:13]=3'b111 and address bit 0 = 0 disarms interrupts, drops the request, cancels a request waiting for its delay cycle, and loads the counter from the reload value.
- R5: A write with address bits [15:13]=3'b111 and address bit 0 = 1 arms interrupts, whatever the data.
- R6: On each counter clock, the counter behaves as follows. If a forced reload is pending, the pending mark is cleared and the counter takes (reload value + 1) mod 256, so 0xFF gives 0x00. Otherwise, a counter at zero takes the reload value. Otherwise, the counter decrements by one.
- R7: A decrement that lands on zero while interrupts are armed raises the request at the next clock edge that has the processor cycle-enable high.
- R8: With processor cycles as the source, the counter is clocked on the 1st, 5th, 9th and later cycle-enables counted since reset in that mode. Line pulses have no effect in this mode.
- R9: With line pulses as the source, only a line pulse clocks the counter. Processor cycle-enables do not clock it and do not move the prescaler.
- R10: Once high, the request holds until an R4 acknowledge write.
- R11: Writes whose address bits [15:13] are neither 3'b110 nor 3'b111 change nothing.
- R12: When a write and a counter clock fall in the same cycle, the counter step uses the state from before the write. The write then overrides the fields it touches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Processor write strobe, one cycle per write |
| wr_addr | input | 16 | Processor write address |
| wr_data | input | 8 | Processor write data |
| cpu_tick | input | 1 | One-cycle enable marking a processor cycle |
| line_pulse | input | 1 | One-cycle pulse per drawn video line |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit counter, a divide-by-4 prescaler and a 16-bit address. With these values the bench can reach the wrap from 0xFF+1 to zero, the reload value of zero, and every phase of the prescaler within a few hundred cycles. Directed runs cover both clock sources, the one-cycle interrupt delay and acknowledge. A long random run then drives writes into the same cycles as counter clocks and delayed requests, where the priority rules of R12 decide the outcome.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  parameter int unsigned IRQC_CNT_W = 8;

  typedef logic [IRQC_CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic latch_wr;
    logic src_wr;
    logic ack_wr;
    logic arm_wr;
  } irqc_wr_t;

  function automatic cnt_t next_count(input logic rl, input cnt_t cnt, input cnt_t lat);
    if (rl)
      return cnt_t'(lat + cnt_t'(1));
    else if (cnt == '0)
      return lat;
    else
      return cnt_t'(cnt - cnt_t'(1));
  endfunction

  function automatic logic lands_on_zero(input logic rl, input cnt_t cnt);
    return !rl && (cnt == cnt_t'(1));
  endfunction

endpackage

// File: rtl/irqc_regdec.sv
module irqc_regdec
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output irqc_wr_t          strb
);
  localparam logic [2:0] WIN_CFG = 3'b110;
  localparam logic [2:0] WIN_ARM = 3'b111;

  logic [2:0] win;
  logic       odd;
  logic       unused_addr_bits;

  assign win = wr_addr[ADDR_W-1 -: 3];
  assign odd = wr_addr[0];
  assign unused_addr_bits = ^wr_addr[ADDR_W-4:1];

  always_comb begin
    strb = '0;
    if (wr_en) begin
      strb.latch_wr = (win == WIN_CFG) && !odd;
      strb.src_wr   = (win == WIN_CFG) &&  odd;
      strb.ack_wr   = (win == WIN_ARM) && !odd;
      strb.arm_wr   = (win == WIN_ARM) &&  odd;
    end
  end
endmodule

// File: rtl/irqc_tickgen.sv
module irqc_tickgen #(
  parameter int unsigned PRE_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_mode,
  input  logic cpu_tick,
  input  logic line_pulse,
  output logic cnt_clk
);
  generate
    if (PRE_DIV > 1) begin : g_div
      localparam int unsigned PW = $clog2(PRE_DIV);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk) begin
        if (!rst_n)
          pre_q <= '0;
        else if (cpu_mode && cpu_tick)
          pre_q <= (pre_q == PW'(PRE_DIV-1)) ? '0 : pre_q + PW'(1);
      end

      assign cnt_clk = cpu_mode ? (cpu_tick && pre_q == '0) : line_pulse;

      a_r9_prescaler_frozen : assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_mode |=> $stable(pre_q) || $past(!rst_n));
    end else begin : g_nodiv
      assign cnt_clk = cpu_mode ? cpu_tick : line_pulse;
    end
  endgenerate
endmodule

// File: rtl/irqc_core.sv
module irqc_core
  import irqc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irqc_wr_t strb,
  input  cnt_t     wr_data,
  input  logic     cpu_tick,
  input  logic     cnt_clk,
  output logic     cpu_mode,
  output logic     irq
);
  cnt_t cnt_q, lat_q, cnt_d;
  logic rl_q, arm_q, fire_q, irq_q, mode_q;
  logic rl_d, arm_d, fire_d, irq_d, mode_d;
  cnt_t lat_d;
  logic hit_zero, fire_take;

  assign hit_zero  = cnt_clk && lands_on_zero(rl_q, cnt_q) && arm_q;
  assign fire_take = cpu_tick && fire_q;

  always_comb begin
    cnt_d  = cnt_clk ? next_count(rl_q, cnt_q, lat_q) : cnt_q;
    rl_d   = cnt_clk ? 1'b0 : rl_q;
    lat_d  = lat_q;
    arm_d  = arm_q;
    mode_d = mode_q;
    irq_d  = irq_q || fire_take;
    fire_d = hit_zero || (fire_q && !fire_take);

    if (strb.latch_wr) begin
      lat_d = wr_data;
      rl_d  = 1'b1;
    end
    if (strb.src_wr) begin
      rl_d   = 1'b1;
      mode_d = wr_data[0];
    end
    if (strb.ack_wr) begin
      arm_d  = 1'b0;
      irq_d  = 1'b0;
      fire_d = 1'b0;
      cnt_d  = lat_q;
    end
    if (strb.arm_wr)
      arm_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lat_q  <= '0;
      rl_q   <= 1'b0;
      arm_q  <= 1'b0;
      fire_q <= 1'b0;
      irq_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lat_q  <= lat_d;
      rl_q   <= rl_d;
      arm_q  <= arm_d;
      fire_q <= fire_d;
      irq_q  <= irq_d;
      mode_q <= mode_d;
    end
  end

  assign irq      = irq_q;
  assign cpu_mode = mode_q;

  a_r10_irq_holds : assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !strb.ack_wr |=> irq_q);

  a_r4_ack_drops : assert property (@(posedge clk) disable iff (!rst_n)
    strb.ack_wr |=> !irq_q && !arm_q && !fire_q);

  a_r5_arm_sets : assert property (@(posedge clk) disable iff (!rst_n)
    strb.arm_wr |=> arm_q);

  a_r6_reload_used : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clk && rl_q && !strb.latch_wr && !strb.src_wr |=> !rl_q);

  a_r7_rise_on_tick : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(cpu_tick) && $past(fire_q));

  a_r8_cpu_clk_needs_tick : assert property (@(posedge clk) disable iff (!rst_n)
    mode_q && cnt_clk |-> cpu_tick);

  a_r2_latch_stored : assert property (@(posedge clk) disable iff (!rst_n)
    strb.latch_wr |=> rl_q && lat_q == $past(wr_data));
endmodule

// File: rtl/irq_downcounter.sv
module irq_downcounter
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned PRE_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              cpu_tick,
  input  logic              line_pulse,
  output logic              irq
);
  irqc_wr_t strb;
  logic     cpu_mode;
  logic     cnt_clk;

  irqc_regdec #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .strb    (strb)
  );

  irqc_tickgen #(.PRE_DIV(PRE_DIV)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_mode   (cpu_mode),
    .cpu_tick   (cpu_tick),
    .line_pulse (line_pulse),
    .cnt_clk    (cnt_clk)
  );

  irqc_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .wr_data  (cnt_t'(wr_data)),
    .cpu_tick (cpu_tick),
    .cnt_clk  (cnt_clk),
    .cpu_mode (cpu_mode),
    .irq      (irq)
  );

  a_r11_outside_ignored : assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr[ADDR_W-1 -: 2] != 2'b11 |-> strb == '0);
endmodule

// File: tb/irq_downcounter_bench.sv
`timescale 1ns/1ps
module irq_downcounter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = 16'h0;
  logic [7:0]  wr_data = 8'h0;
  logic        cpu_tick = 1'b0;
  logic        line_pulse = 1'b0;
  logic        irq;

  int n_vec = 0, n_bad = 0;
  string tag = "R1";
  bit done = 0;

  int m_cnt = 0, m_lat = 0, m_pre = 0;
  bit m_rl = 0, m_arm = 0, m_fp = 0, m_irq = 0, m_mode = 0;

  always #2.5 clk = ~clk;

  irq_downcounter u_irq_downcounter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cpu_tick(cpu_tick), .line_pulse(line_pulse), .irq(irq)
  );

  task automatic model_step();
    bit fire_set = 0, take;
    bit ev;
    ev = m_mode ? (cpu_tick && m_pre == 0) : line_pulse;
    if (m_mode && cpu_tick) m_pre = (m_pre + 1) % 4;
    if (ev) begin
      if (m_rl) begin m_rl = 0; m_cnt = (m_lat + 1) % 256; end
      else if (m_cnt == 0) m_cnt = m_lat;
      else begin m_cnt = m_cnt - 1; if (m_cnt == 0 && m_arm) fire_set = 1; end
    end
    take = cpu_tick && m_fp;
    if (take) m_irq = 1;
    m_fp = fire_set | (m_fp & ~take);
    if (wr_en && wr_addr[15:13] == 3'd6) begin
      m_rl = 1;
      if (wr_addr[0]) m_mode = wr_data[0]; else m_lat = wr_data;
    end else if (wr_en && wr_addr[15:13] == 3'd7) begin
      if (wr_addr[0]) m_arm = 1;
      else begin m_arm = 0; m_irq = 0; m_fp = 0; m_cnt = m_lat; end
    end
  endtask

  task automatic check(bit act, bit exp, string req);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s irq actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(bit we, logic [15:0] a, logic [7:0] d, bit t, bit l);
    @(negedge clk);
    check(irq, m_irq, tag);
    wr_en = we; wr_addr = a; wr_data = d; cpu_tick = t; line_pulse = l;
    @(posedge clk);
    if (rst_n) model_step();
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d); cyc(1, a, d, 0, 0); endtask
  task automatic ticks(int n); for (int i = 0; i < n; i++) cyc(0, 16'h0, 8'h0, 1, 0); endtask
  task automatic lines(int n); for (int i = 0; i < n; i++) cyc(0, 16'h0, 8'h0, 0, 1); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5.0);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] pick [6];
    pick = '{16'hC000, 16'hC001, 16'hE000, 16'hE001, 16'h8000, 16'hA001};
    tag = "R1";
    for (int i = 0; i < 4; i++) cyc(0, 16'h0, 8'h0, 0, 0);
    @(negedge clk); rst_n = 1;
    ticks(3); lines(3);
    // line-pulse source, reload of 3 -> four clocks to zero
    tag = "R2"; wr(16'hC000, 8'd3);
    tag = "R5"; wr(16'hE001, 8'h00);
    tag = "R6"; lines(4);
    tag = "R9"; ticks(6);
    tag = "R7"; lines(1); cyc(0, 16'h0, 8'h0, 0, 0); ticks(1);
    n_vec++; if (m_irq !== 1'b1) begin n_bad++; $display("FAIL R7 model irq actual=%0b expected=1", m_irq); end
    tag = "R10"; ticks(10); lines(5);
    tag = "R4"; wr(16'hE000, 8'h55); ticks(2);
    // processor-cycle source
    tag = "R3"; wr(16'hC001, 8'h01); wr(16'hC000, 8'd2); wr(16'hE001, 8'hAA);
    tag = "R8"; lines(8); ticks(20);
    tag = "R4"; wr(16'hE000, 8'h00); ticks(3);
    // wrap of 0xFF+1
    tag = "R6"; wr(16'hC000, 8'hFF); wr(16'hE001, 8'h00); ticks(12);
    tag = "R6"; wr(16'hC000, 8'h00); ticks(12);
    tag = "R11"; wr(16'h8000, 8'h01); wr(16'hA001, 8'h00); wr(16'h6000, 8'hFF); wr(16'h9FFF, 8'h00); ticks(16);
    tag = "R3"; wr(16'hC001, 8'h00); ticks(8); lines(6);
    tag = "R12";
    for (int i = 0; i < 4000; i++) begin
      bit we = ($urandom % 12) == 0;
      cyc(we, pick[$urandom % 6], 8'($urandom % 6), $urandom % 2, ($urandom % 6) == 0);
    end
    cyc(0, 16'h0, 8'h0, 0, 0);
    finish_run();
  end
endmodule